// File: doc/BRIEF.md
# 64-Bit Self-Synchronizing Scrambler and Descrambler

This block whitens or restores a serial bit stream that is carried 64 bits at a time. Each bit of the stream is combined with two bits of its own scrambled past, using the polynomial 1 + x^39 + x^58. A single mode input picks the direction. In scramble mode the result is fed back into the history. In descramble mode the received bit is fed back. Because of this, a descrambler locks to any scrambler after 58 bits, with no shared seed and no setup exchange.

All 64 serial steps are unrolled into one clock cycle. Bit 0 of each word is the earliest bit in time. A word presented with its valid flag high produces a registered result one clock later. When the valid flag is low, the 58-bit history is frozen. A corrupted received bit affects the output at its own position and at the positions 39 and 58 bits later, and at no other position.

Top module: `ssc_scrambler`

## Requirements
- R1: After a synchronous reset the output valid is 0, the output word is 0, and the history is all ones, so the first scrambled word of zeros from reset equals the bench's serial model seeded with all ones.
- R2: In scramble mode (mode_descr = 0), each output bit is the input bit XOR the scrambled bits 39 and 58 positions earlier in the stream. Word bit 0 is the earliest bit and bit 63 is the latest.
- R3: In descramble mode (mode_descr = 1), each output bit is the input bit XOR the received bits 39 and 58 positions earlier in the stream, with the same bit order.
- R4: The history advances by 64 bits per valid word. In scramble mode it takes in the output bits, and in descramble mode it takes in the input bits. The most recent bit (word bit 63) becomes history position 0.
- R5: A cycle with in_vld = 0 gives out_vld = 0 on the next cycle and leaves the history unchanged for the next valid word.
- R6: A word presented with in_vld = 1 is delivered with out_vld = 1 exactly one clock later.
- R7: Descrambling a scrambled stream starting from any history returns the original data from stream bit 58 onward (word 0 bits 63..58 and every later word).
- R8: A single flipped received bit at stream position p corrupts only the output bits at p, p+39 and p+58. Output words after that are error free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_descr | input | 1 | 0 = scramble, 1 = descramble |
| in_vld | input | 1 | Input word qualifier |
| in_data | input | 64 | Input word, bit 0 earliest |
| out_vld | output | 1 | Output word qualifier |
| out_data | output | 64 | Result word, bit 0 earliest |

## Verification
Every result arrives exactly one rising edge after its word is sampled. The bench drives each word at a falling edge and reads out_vld and out_data at the next falling edge, so each check lands on the register stage that holds that word's result. A serial bench model with its own 58-bit history sets the expectation for every valid word, and its history moves only on valid words, matching R5. The lock-on and error-spread checks compare against the original payload rather than the model. They inspect word 0 bits 63..58 and later words for R7, and, for R8, the word holding the flipped bit and the two words after it.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int SSC_DATA_W   = 64;
  localparam int SSC_HIST_W   = 58;
  localparam int SSC_TAP_NEAR = 39;
  localparam int SSC_TAP_FAR  = 58;

  typedef enum logic {
    MODE_SCR   = 1'b0,
    MODE_DESCR = 1'b1
  } mode_e;
endpackage

// File: rtl/ssc_unroll.sv
module ssc_unroll #(
  parameter int DATA_W   = 64,
  parameter int HIST_W   = 58,
  parameter int TAP_NEAR = 39,
  parameter int TAP_FAR  = 58
) (
  input  logic [HIST_W-1:0] hist_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              descr_i,
  output logic [DATA_W-1:0] dout_o,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] h;
  logic              o_bit;
  logic              fb;

  // serial steps in time order: bit 0 first; h[0] is newest stream bit
  always_comb begin
    h      = hist_i;
    dout_o = '0;
    o_bit  = 1'b0;
    fb     = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      o_bit     = din_i[i] ^ h[TAP_NEAR-1] ^ h[TAP_FAR-1];
      dout_o[i] = o_bit;
      fb        = descr_i ? din_i[i] : o_bit;
      h         = {h[HIST_W-2:0], fb};
    end
    hist_o = h;
  end
endmodule

// File: rtl/ssc_history.sv
module ssc_history #(
  parameter int HIST_W = 58
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [HIST_W-1:0] hist_d,
  output logic [HIST_W-1:0] hist_q
);
  always_ff @(posedge clk) begin
    if (rst)       hist_q <= '1;
    else if (load) hist_q <= hist_d;
  end

  // R5: idle cycle freezes the history
  assert_hist_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(hist_q))
    else $error("history moved on idle cycle");
endmodule

// File: rtl/ssc_scrambler.sv
module ssc_scrambler
  import ssc_pkg::*;
#(
  parameter int DATA_W   = SSC_DATA_W,
  parameter int HIST_W   = SSC_HIST_W,
  parameter int TAP_NEAR = SSC_TAP_NEAR,
  parameter int TAP_FAR  = SSC_TAP_FAR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_descr,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);
  mode_e             mode_sel;
  logic              descr;
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_n;
  logic [DATA_W-1:0] word_n;

  assign mode_sel = mode_e'(mode_descr);
  assign descr    = (mode_sel == MODE_DESCR);

  ssc_unroll #(
    .DATA_W(DATA_W), .HIST_W(HIST_W),
    .TAP_NEAR(TAP_NEAR), .TAP_FAR(TAP_FAR)
  ) u_unroll (
    .hist_i (hist_q),
    .din_i  (in_data),
    .descr_i(descr),
    .dout_o (word_n),
    .hist_o (hist_n)
  );

  ssc_history #(.HIST_W(HIST_W)) u_hist (
    .clk   (clk),
    .rst   (rst),
    .load  (in_vld),
    .hist_d(hist_n),
    .hist_q(hist_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_data <= word_n;
    end
  end

  // R6: valid travels with one cycle of latency
  assert_vld_latency_R6: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld)
    else $error("out_vld missing");
  assert_vld_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld)
    else $error("out_vld on idle cycle");

  // R2: earliest bit uses the history as it stood before the word
  assert_first_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !mode_descr) |=>
      out_data[0] == ($past(in_data[0]) ^ $past(hist_q[TAP_NEAR-1]) ^ $past(hist_q[TAP_FAR-1])))
    else $error("bit 0 scramble mismatch");

  // R4: history source per mode (newest word bit lands at position 0)
  generate
    if (DATA_W >= HIST_W) begin : g_hist_src
      logic [HIST_W-1:0] rev_in;
      logic [HIST_W-1:0] rev_out;
      for (genvar k = 0; k < HIST_W; k++) begin : g_rev
        assign rev_in[k]  = in_data[DATA_W-1-k];
        assign rev_out[k] = out_data[DATA_W-1-k];
      end
      assert_hist_from_in_R4: assert property (@(posedge clk) disable iff (rst)
        (in_vld && mode_descr) |=> hist_q == $past(rev_in))
        else $error("descramble history not from input");
      assert_hist_from_out_R4: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !mode_descr) |=> hist_q == rev_out)
        else $error("scramble history not from output");
    end
  endgenerate
endmodule

// File: tb/ssc_scrambler_test.sv
`timescale 1ns/1ps
module ssc_scrambler_test;
  localparam int DW = 64;
  localparam int HW = 58;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_descr = 1'b0;
  logic          in_vld = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_vld;
  logic [DW-1:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [HW-1:0] mh;

  always #10 clk = ~clk;

  ssc_scrambler uut (
    .clk(clk), .rst(rst), .mode_descr(mode_descr),
    .in_vld(in_vld), .in_data(in_data),
    .out_vld(out_vld), .out_data(out_data)
  );

  function automatic logic [DW-1:0] mdl(input logic [HW-1:0] h_in, input logic [DW-1:0] d,
                                        input logic dsc, output logic [HW-1:0] h_out);
    logic [HW-1:0] h;
    logic [DW-1:0] o;
    h = h_in;
    o = '0;
    for (int i = 0; i < DW; i++) begin
      o[i] = d[i] ^ h[38] ^ h[57];
      h = {h[HW-2:0], dsc ? d[i] : o[i]};
    end
    h_out = h;
    return o;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_word(input logic [DW-1:0] d, input logic dsc, input logic v,
                          input string req, output logic [DW-1:0] got);
    logic [DW-1:0] exp;
    logic [HW-1:0] hn;
    exp = '0;
    in_data = d; mode_descr = dsc; in_vld = v;
    if (v) begin
      exp = mdl(mh, d, dsc, hn);
      mh = hn;
    end
    @(negedge clk);
    if (v) begin
      chk("R6 out_vld", {63'd0, out_vld}, 64'd1);
      chk(req, out_data, exp);
    end else begin
      chk("R5 out_vld idle", {63'd0, out_vld}, 64'd0);
    end
    got = out_data;
    in_vld = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] got;
    logic [DW-1:0] xs [6];
    logic [DW-1:0] ys [6];
    logic [DW-1:0] seed_dummy;
    seed_dummy = 64'($urandom(32'd1234));
    mh = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 out_vld after reset", {63'd0, out_vld}, 64'd0);
    chk("R1 out_data after reset", out_data, 64'd0);

    // R1/R2: zeros from the all-ones history
    run_word(64'd0, 1'b0, 1'b1, "R1 R2 zero word from reset", got);
    // R2: single bit at earliest position, then latest
    run_word(64'd1, 1'b0, 1'b1, "R2 bit0 directed", got);
    run_word(64'h8000_0000_0000_0000, 1'b0, 1'b1, "R2 bit63 directed", got);
    // R3/R4 directed: all ones descrambled
    run_word('1, 1'b1, 1'b1, "R3 R4 all ones descramble", got);

    // random mix of modes and idle cycles (R2 R3 R4 R5)
    for (int n = 0; n < 40; n++) begin
      logic v, m;
      v = ($urandom % 4) != 0;
      m = $urandom % 2;
      run_word({$urandom, $urandom}, m, v, m ? "R3 random descramble" : "R2 random scramble", got);
    end

    // R7: scramble a payload, then descramble from the leftover history
    for (int k = 0; k < 6; k++) begin
      xs[k] = {$urandom, $urandom};
      run_word(xs[k], 1'b0, 1'b1, "R2 payload scramble", ys[k]);
    end
    run_word(ys[0], 1'b1, 1'b1, "R3 lock word0", got);
    chk("R7 word0 bits 63..58", {58'd0, got[63:58]}, {58'd0, xs[0][63:58]});
    for (int k = 1; k < 6; k++) begin
      if (k == 3) run_word(64'd0, 1'b1, 1'b0, "R5 idle", got);
      run_word(ys[k], 1'b1, 1'b1, "R3 lock stream", got);
      chk("R7 recovered word", got, xs[k]);
    end

    // R8: single received bit error at word1 bit 10
    for (int k = 0; k < 5; k++) begin
      xs[k] = {$urandom, $urandom};
      run_word(xs[k], 1'b0, 1'b1, "R2 error payload", ys[k]);
    end
    run_word(ys[0], 1'b1, 1'b1, "R3 error word0", got);
    run_word(ys[1] ^ (64'd1 << 10), 1'b1, 1'b1, "R3 error word1", got);
    chk("R8 error spread word1", got ^ xs[1], (64'd1 << 10) | (64'd1 << 49));
    run_word(ys[2], 1'b1, 1'b1, "R3 error word2", got);
    chk("R8 error spread word2", got ^ xs[2], 64'd1 << 4);
    run_word(ys[3], 1'b1, 1'b1, "R3 error word3", got);
    chk("R8 clean after history", got, xs[3]);
    run_word(ys[4], 1'b1, 1'b1, "R3 error word4", got);
    chk("R8 clean later", got, xs[4]);

    // R1 again: reset mid-stream restores the all-ones history
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mh = '1;
    chk("R1 out_vld after second reset", {63'd0, out_vld}, 64'd0);
    run_word(64'd0, 1'b0, 1'b1, "R1 zero word after second reset", got);

    if (seed_dummy == 64'hFFFF_FFFF_FFFF_FFFF) $display("seed note");
    finish_run();
  end
endmodule